// File: doc/BRIEF.md
# USB Wakeup Event Latch and Interrupt Gate

This unit sits beside a microcontroller core whose clock can be stopped. It watches the two USB data lines and two external interrupt inputs, and records three kinds of wakeup cause in a status byte. A mask byte then selects which causes may raise a single active-high line. That line is both the core's interrupt input and the request that restarts its clock.

Two causes are latched events. The first is a bus reset, seen as both data lines held low (SE0) for a qualifying number of bit times. The second is a global resume, seen as the bus leaving the idle J state while the device is suspended. Both stay set until software writes a 1 to their bit. The third cause is a live level: the OR of an ATA interrupt-pending input and a GPIO interrupt input. Both bytes sit on a simple byte-wide register bus. Writes are synchronous and reads are combinational.

The bit time follows a speed-select input, and each bit time lasts a parameterised number of clock cycles. A two-flop synchronizer sits in front of the line inputs.

Top module: `wk_wake_unit`

## Requirements
- R1: After synchronous reset, the status byte at address 0xA0 reads 0x00 while both external interrupt inputs are low, the mask byte at 0xA6 reads 0xFF, and `wake_irq` is 0.
- R2: Status bit 2 (bus reset) sets when both lines are low for at least SE0_BITS bit times, and stays clear for a shorter span. A bit time is FS_DIV clock cycles when `ls_sel`=0 and LS_DIV cycles when `ls_sel`=1. Once set, the bit holds until it is cleared by software.
- R3: The SE0 count restarts whenever either line goes high. Two short SE0 spans split by one cycle with a line high do not add together.
- R4: Status bit 1 (resume) sets when the lines leave J (`usb_dp`=1, `usb_dm`=0) while `suspend`=1. It does not set when `suspend`=0, and it does not set on entering J.
- R5: Status bit 0 reads `ata_irq | gpio_irq` live. It is not latched, and writes do not affect it.
- R6: Writing a 1 to status bit 1 or bit 2 clears that bit, and writing 0 leaves it unchanged. Status bits 7..3 read 0.
- R7: If a hardware set and a software clear of the same status bit fall in the same cycle, the bit ends up set.
- R8: The mask bits 2..0 at 0xA6 are writable, with 0 enabling and 1 masking the status bit in the same position. Mask bits 7..3 always read 1.
- R9: `wake_irq` is a register that becomes the OR of the status bits 2..0 whose mask bit is 0, one clock after that condition holds. Status bits set regardless of the mask.
- R10: Reads of any address other than 0xA0 and 0xA6 return 0x00, and writes to such addresses change neither byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_dp | input | 1 | USB D+ line level (asynchronous) |
| usb_dm | input | 1 | USB D- line level (asynchronous) |
| ls_sel | input | 1 | Bit-time select: 0 full speed, 1 low speed |
| suspend | input | 1 | Device is in global suspend |
| ata_irq | input | 1 | ATA interrupt-pending level |
| gpio_irq | input | 1 | GPIO interrupt level |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational register read data |
| wake_irq | output | 1 | Registered interrupt and clock-restart request |

## Verification
The bench sweeps the SE0 span from three cycles below the threshold to two cycles above it, at both speeds. A counter that is off by one, or that uses the wrong divider, would set bit 2 one span too early or too late.

Split SE0 spans, broken by each line in turn, target a counter that fails to restart and so accumulates across the gap. Resume is tried with suspend low and on entry into J, which a detector keyed on the wrong edge would flag.

A software clear is aimed at the exact cycle of a resume event, so a design that lets the clear win loses the event. The interrupt is sampled one cycle after an unmask to expose a combinational path that should be registered.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam logic [7:0] ADDR_STAT = 8'hA0;
  localparam logic [7:0] ADDR_MASK = 8'hA6;
  localparam int BIT_RST = 2;
  localparam int BIT_RES = 1;
  localparam int BIT_EXT = 0;
  localparam int NSRC    = 3;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/wk_se0_det.sv
module wk_se0_det #(
  parameter int FS_DIV = 4,
  parameter int LS_DIV = 32,
  parameter int NBITS  = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic ls_sel,
  input  logic se0,
  output logic hit
);
  localparam int MAXD = (FS_DIV > LS_DIV) ? FS_DIV : LS_DIV;
  localparam int DW   = (MAXD > 1) ? $clog2(MAXD) : 1;
  localparam int BW   = $clog2(NBITS + 1);

  logic [DW-1:0] div_q;
  logic [BW-1:0] bits_q;
  logic [DW-1:0] lim;
  logic          tick;

  assign lim  = ls_sel ? DW'(LS_DIV - 1) : DW'(FS_DIV - 1);
  assign tick = (div_q == lim);
  assign hit  = se0 && tick && (bits_q == BW'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (rst || !se0) begin
      div_q  <= '0;
      bits_q <= '0;
    end else if (bits_q != BW'(NBITS)) begin
      if (tick) begin
        div_q  <= '0;
        bits_q <= bits_q + 1'b1;
      end else begin
        div_q  <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wk_resume_det.sv
module wk_resume_det (
  input  logic clk,
  input  logic rst,
  input  logic j_now,
  input  logic suspend,
  output logic evt
);
  logic j_prev;

  always_ff @(posedge clk) begin
    if (rst) j_prev <= 1'b0;
    else     j_prev <= j_now;
  end

  assign evt = suspend && j_prev && !j_now;
endmodule

// File: rtl/wk_wake_unit.sv
module wk_wake_unit
  import wk_pkg::*;
#(
  parameter int FS_DIV   = 4,
  parameter int LS_DIV   = 32,
  parameter int SE0_BITS = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       usb_dp,
  input  logic       usb_dm,
  input  logic       ls_sel,
  input  logic       suspend,
  input  logic       ata_irq,
  input  logic       gpio_irq,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       wake_irq
);
  logic [1:0]      line_s;
  logic            se0, j_now;
  logic            se0_hit, res_evt;
  logic [1:0]      ev_q;      // [1]=bus reset, [0]=resume
  logic [1:0]      ev_set, ev_clr;
  logic [NSRC-1:0] mask_q;
  logic            ext_live;
  logic [NSRC-1:0] src;
  logic            wdata_unused;

  assign wdata_unused = &reg_wdata[7:3];

  wk_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({usb_dp, usb_dm}),
    .q   (line_s)
  );

  assign se0   = !line_s[1] && !line_s[0];
  assign j_now =  line_s[1] && !line_s[0];

  wk_se0_det #(.FS_DIV(FS_DIV), .LS_DIV(LS_DIV), .NBITS(SE0_BITS)) u_se0 (
    .clk    (clk),
    .rst    (rst),
    .ls_sel (ls_sel),
    .se0    (se0),
    .hit    (se0_hit)
  );

  wk_resume_det u_res (
    .clk     (clk),
    .rst     (rst),
    .j_now   (j_now),
    .suspend (suspend),
    .evt     (res_evt)
  );

  assign ext_live = ata_irq | gpio_irq;
  assign ev_set   = {se0_hit, res_evt};
  assign ev_clr   = (reg_wr && reg_addr == ADDR_STAT) ?
                    reg_wdata[BIT_RST:BIT_RES] : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) ev_q <= 2'b00;
    else     ev_q <= (ev_q & ~ev_clr) | ev_set;
  end

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '1;
    else if (reg_wr && reg_addr == ADDR_MASK)
      mask_q <= reg_wdata[NSRC-1:0];
  end

  assign src = {ev_q, ext_live};

  always_ff @(posedge clk) begin
    if (rst) wake_irq <= 1'b0;
    else     wake_irq <= |(src & ~mask_q);
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_STAT: reg_rdata = {5'b00000, src};
      ADDR_MASK: reg_rdata = {5'b11111, mask_q};
      default:   reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/wk_wake_chk.sv
module wk_wake_chk
  import wk_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [7:0] reg_addr,
  input logic       reg_wr,
  input logic       clr_rst_bit,
  input logic [7:0] reg_rdata,
  input logic       wake_irq,
  input logic       suspend,
  input logic       ata_irq,
  input logic       gpio_irq,
  input logic [1:0] ev_q,
  input logic [1:0] ev_set,
  input logic [2:0] mask_q
);
  logic wr_clr;
  logic live_on;

  assign wr_clr  = reg_wr && reg_addr == ADDR_STAT && clr_rst_bit;
  assign live_on = |({ev_q, ata_irq | gpio_irq} & ~mask_q);

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    ev_q[1] && !wr_clr |=> ev_q[1]);

  p_resume_gate_r4: assert property (@(posedge clk) disable iff (rst)
    ev_set[0] |-> suspend);

  p_ext_live_r5: assert property (@(posedge clk) disable iff (rst)
    reg_addr == ADDR_STAT |-> reg_rdata[0] == (ata_irq | gpio_irq));

  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    wr_clr && !ev_set[1] |=> !ev_q[1]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    ev_set[1] |=> ev_q[1]);

  p_mask_rsvd_r8: assert property (@(posedge clk) disable iff (rst)
    reg_addr == ADDR_MASK |-> reg_rdata[7:3] == 5'b11111);

  p_irq_on_r9: assert property (@(posedge clk) disable iff (rst)
    live_on |=> wake_irq);

  p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
    !live_on |=> !wake_irq);

  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    reg_addr != ADDR_STAT && reg_addr != ADDR_MASK |-> reg_rdata == 8'h00);
endmodule

bind wk_wake_unit wk_wake_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .clr_rst_bit (reg_wdata[2]),
  .reg_rdata   (reg_rdata),
  .wake_irq    (wake_irq),
  .suspend     (suspend),
  .ata_irq     (ata_irq),
  .gpio_irq    (gpio_irq),
  .ev_q        (ev_q),
  .ev_set      (ev_set),
  .mask_q      (mask_q)
);

// File: tb/wk_wake_unit_bench.sv
module wk_wake_unit_bench;
  localparam int FS = 2;
  localparam int LS = 5;
  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       usb_dp = 1'b1, usb_dm = 1'b0;
  logic       ls_sel = 1'b0, suspend = 1'b0;
  logic       ata_irq = 1'b0, gpio_irq = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       wake_irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  wk_wake_unit #(.FS_DIV(FS), .LS_DIV(LS), .SE0_BITS(NB)) u_wk_wake_unit (
    .clk(clk), .rst(rst), .usb_dp(usb_dp), .usb_dm(usb_dm),
    .ls_sel(ls_sel), .suspend(suspend), .ata_irq(ata_irq),
    .gpio_irq(gpio_irq), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_irq(wake_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic se0_span(input int len);
    @(negedge clk);
    usb_dp = 1'b0; usb_dm = 1'b0;
    repeat (len) @(negedge clk);
    usb_dp = 1'b1; usb_dm = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1: reset state
    rd(8'hA0, v); check("R1 status", v, 8'h00);
    rd(8'hA6, v); check("R1 mask", v, 8'hFF);
    check("R1 irq", {7'b0, wake_irq}, 8'h00);

    // R5: live external bit
    ata_irq = 1'b1; rd(8'hA0, v); check("R5 ata", v, 8'h01);
    ata_irq = 1'b0; gpio_irq = 1'b1; rd(8'hA0, v); check("R5 gpio", v, 8'h01);
    gpio_irq = 1'b0; rd(8'hA0, v); check("R5 none", v, 8'h00);
    ata_irq = 1'b1; wr(8'hA0, 8'hFF); rd(8'hA0, v); check("R5 write ignored", v, 8'h01);
    ata_irq = 1'b0; rd(8'hA0, v); check("R5 not latched", v, 8'h00);

    // R10: unmapped addresses
    for (int a = 0; a < 256; a++) begin
      if (a != 8'hA0 && a != 8'hA6) begin
        rd(a[7:0], v);
        if (v !== 8'h00) check("R10 unmapped read", v, 8'h00);
      end
    end
    check("R10 unmapped sweep", 8'h00, 8'h00);
    wr(8'hA2, 8'h00); rd(8'hA6, v); check("R10 stray write", v, 8'hFF);

    // R8: mask register
    wr(8'hA6, 8'h00); rd(8'hA6, v); check("R8 mask 00", v, 8'hF8);
    wr(8'hA6, 8'h05); rd(8'hA6, v); check("R8 mask 05", v, 8'hFD);
    wr(8'hA6, 8'hFF);

    // R2: SE0 threshold sweep at both speeds
    for (int s = 0; s < 2; s++) begin
      int thr;
      ls_sel = s[0];
      thr = NB * (s == 0 ? FS : LS);
      for (int len = thr - 3; len <= thr + 2; len++) begin
        wr(8'hA0, 8'h06);
        idle(2);
        se0_span(len);
        idle(4);
        rd(8'hA0, v);
        check($sformatf("R2 ls=%0d len=%0d", s, len), v & 8'h04,
              (len >= thr) ? 8'h04 : 8'h00);
      end
    end
    ls_sel = 1'b0;

    // R6: write 0 leaves bit, write 1 clears, reserved read 0
    wr(8'hA0, 8'h00); rd(8'hA0, v); check("R6 write0 keeps", v, 8'h04);
    wr(8'hA0, 8'h04); rd(8'hA0, v); check("R6 write1 clears", v, 8'h00);

    // R3: interrupted SE0 does not accumulate
    begin
      int thr;
      thr = NB * FS;
      @(negedge clk); usb_dp = 1'b0; usb_dm = 1'b0;
      idle(thr - 1);
      usb_dp = 1'b1; idle(1); usb_dp = 1'b0;
      idle(thr - 1);
      usb_dm = 1'b1; idle(1); usb_dm = 1'b0;
      idle(thr - 1);
      usb_dp = 1'b1; usb_dm = 1'b0;
      idle(4);
      rd(8'hA0, v); check("R3 split spans", v & 8'h04, 8'h00);
      se0_span(thr); idle(4);
      rd(8'hA0, v); check("R3 full span after split", v & 8'h04, 8'h04);
      wr(8'hA0, 8'h04);
    end

    // R4: resume detection
    suspend = 1'b1;
    @(negedge clk); usb_dp = 1'b0; usb_dm = 1'b1;
    idle(4);
    rd(8'hA0, v); check("R4 leave J suspended", v, 8'h02);
    wr(8'hA0, 8'h02); rd(8'hA0, v); check("R6 clear resume", v, 8'h00);
    @(negedge clk); usb_dp = 1'b1; usb_dm = 1'b0;
    idle(4);
    rd(8'hA0, v); check("R4 enter J no event", v, 8'h00);
    suspend = 1'b0;
    @(negedge clk); usb_dp = 1'b0; usb_dm = 1'b1;
    idle(4);
    rd(8'hA0, v); check("R4 not suspended", v, 8'h00);
    @(negedge clk); usb_dp = 1'b1; usb_dm = 1'b0;
    idle(4);

    // R7: set and clear in the same cycle
    suspend = 1'b1;
    @(negedge clk); usb_dp = 1'b0; usb_dm = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 8'hA0; reg_wdata = 8'h02; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(8'hA0, v); check("R7 set wins", v, 8'h02);
    suspend = 1'b0;
    @(negedge clk); usb_dp = 1'b1; usb_dm = 1'b0;
    idle(4);

    // R9: masking and registered interrupt
    rd(8'hA0, v); check("R9 sets while masked", v, 8'h02);
    check("R9 masked irq", {7'b0, wake_irq}, 8'h00);
    wr(8'hA6, 8'hFD);
    check("R9 irq one cycle late", {7'b0, wake_irq}, 8'h00);
    idle(1);
    check("R9 unmasked irq", {7'b0, wake_irq}, 8'h01);
    wr(8'hA0, 8'h02); idle(1);
    check("R9 irq drops after clear", {7'b0, wake_irq}, 8'h00);
    wr(8'hA6, 8'hFE);
    gpio_irq = 1'b1; idle(2);
    check("R9 ext irq", {7'b0, wake_irq}, 8'h01);
    gpio_irq = 1'b0; idle(2);
    check("R9 ext irq off", {7'b0, wake_irq}, 8'h00);
    wr(8'hA6, 8'hFB);
    se0_span(NB * FS); idle(4);
    check("R9 reset irq", {7'b0, wake_irq}, 8'h01);
    ata_irq = 1'b1; idle(1);
    rd(8'hA0, v); check("R9 combined status", v, 8'h05);
    ata_irq = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule